// File: doc/BRIEF.md
# QAM Modulator with Merged Pulse-Shape and Carrier Tables

This block turns a stream of symbol words into a digital passband sample stream for a square QAM constellation of 4, 16 or 64 points. A word is accepted through a valid/ready pair. Its upper half selects the in-phase level and its lower half selects the quadrature level. The two coordinates are then held for exactly one symbol.

For every sample inside that symbol, each coordinate is multiplied by one entry of a precomputed table. Each table entry already holds a Hann window sample multiplied by the carrier cosine or the carrier sine. The two products are added, scaled and saturated. The result leaves as one signed sample per sample-enable pulse.

Two constraints remove the need for a shaping filter and a free-running oscillator. The window lasts exactly one symbol. The symbol holds a whole number of carrier periods, and each carrier period holds a whole number of samples. One table index therefore serves both the window and the carrier.

The enable input sets the sample rate. Tying it high runs the block at the clock rate. Symbols follow one another with no gap. When no word is offered at a symbol boundary, the block sends the origin for that whole symbol.

Top module: `qam_tx_mod`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sample` is 0. `in_ready` stays 0 until the first `sample_en` cycle, and that first cycle is a symbol boundary.
- R2: `in_ready` is high exactly in those cycles where `sample_en` is high and the current symbol has produced its last (SPS-th) sample, or in the first such cycle after reset. A word is taken only when `in_valid` is also high. The value of `in_word` in any other cycle has no effect on the output.
- R3: For a word of BITS_PER_SYM bits, let H = BITS_PER_SYM/2 and L = 2^H. The field word[BITS_PER_SYM-1:H] is the in-phase index k_i and word[H-1:0] is the quadrature index k_q. Both are plain binary. The level for index k is (2k - (L-1)) * (512/L). For 64 points the levels are therefore -448, -320, ..., +448.
- R4: The sample emitted for index i of a symbol equals sat(floor((I*C[i] + Q*S[i]) / 2^OUT_SHIFT)). Here C[i] = round(511 * 0.5*(1-cos(2*pi*i/SPS)) * cos(2*pi*i/SPC)), and S[i] is the same expression with sin in place of the second cos. Rounding is half away from zero.
- R5: Each `sample_en` cycle produces exactly one `out_valid` pulse. That pulse falls in the cycle that follows the second rising edge after the enable edge.
- R6: If `in_valid` is low at a symbol boundary, the whole next symbol uses I = Q = 0, so all SPS of its samples are 0. A word offered later waits, untouched, for the next boundary.
- R7: The full-precision sum, after the shift, is clamped to [-2^(OUT_W-1), 2^(OUT_W-1)-1] and never wraps. With the defaults, the corner points of 64-QAM reach both limits.
- R8: While `sample_en` is low, the sample index and the held coordinates do not change. A throttled enable yields the same sample values as a continuous one.
- R9: Each symbol spans exactly SPS samples with indices 0 to SPS-1. The next symbol's index 0 follows the previous symbol's index SPS-1 with no idle sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | One-cycle strobe that advances the block by one output sample |
| in_valid | input | 1 | A symbol word is offered |
| in_word | input | BITS_PER_SYM | Symbol word; upper half selects I, lower half selects Q |
| in_ready | output | 1 | The word is taken in this cycle if `in_valid` is high |
| out_valid | output | 1 | `out_sample` carries a new sample |
| out_sample | output | OUT_W | Signed, saturated passband sample |

## Verification
The bench aims at the corners that a plausible slip would break, and each slip has a visible symptom.
- **Boundary off by one:** the ready strobe would drift away from every SPS-th enable. Symbols would then gain or lose a sample.
- **Missing symbol:** without the origin fallback, the previous point would repeat instead of producing SPS zero samples.
- **Throttled enable:** if the index or coordinates moved on idle cycles, the sample values would change when the enable is slowed down.
- **Overflow:** the 64-QAM corner points drive the peak of the window past the output range. A wrapping sum would flip sign exactly where the clamped value is expected.
- **Reset mid-symbol:** reset is applied in the middle of a symbol. A design that does not restart the index at a fresh boundary fails this case.

// File: rtl/qam_tx_pkg.sv
package qam_tx_pkg;

  // Axis level for index k on an axis with 2**half levels, full scale 2**(coord_w-1).
  function automatic int axis_level(input int k, input int half, input int coord_w);
    int step;
    step = (1 << (coord_w - 1)) >> half;
    return (2 * k - ((1 << half) - 1)) * step;
  endfunction

  // Hann window times carrier cosine (use_sin=0) or sine (use_sin=1), rounded.
  function automatic int shape_coef(input int i, input int sps, input int spc,
                                    input int tab_w, input bit use_sin);
    real two_pi;
    real win;
    real car;
    real v;
    two_pi = 6.283185307179586;
    win = 0.5 * (1.0 - $cos(two_pi * i / sps));
    car = use_sin ? $sin(two_pi * i / spc) : $cos(two_pi * i / spc);
    v = win * car * ((1 << (tab_w - 1)) - 1);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  // Clamp a signed value to a w-bit two's-complement range.
  function automatic longint clip(input longint v, input int w);
    longint lim;
    lim = longint'(1) <<< (w - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/qam_tx_seq.sv
module qam_tx_seq #(
  parameter int SPS   = 40,
  parameter int IDX_W = $clog2(SPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             take,
  output logic             skip,
  output logic [IDX_W-1:0] idx
);
  logic at_end;

  assign at_end   = (idx == IDX_W'(SPS - 1));
  assign in_ready = sample_en & at_end;
  assign take     = in_ready & in_valid;
  assign skip     = in_ready & ~in_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= IDX_W'(SPS - 1);
    end else if (sample_en) begin
      idx <= at_end ? '0 : idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/qam_tx_map.sv
module qam_tx_map
  import qam_tx_pkg::*;
#(
  parameter int BITS_PER_SYM = 6,
  parameter int COORD_W      = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic                      skip,
  input  logic [BITS_PER_SYM-1:0]   word,
  output logic signed [COORD_W-1:0] cur_i,
  output logic signed [COORD_W-1:0] cur_q
);
  localparam int HALF = BITS_PER_SYM / 2;

  logic [HALF-1:0]           k_i;
  logic [HALF-1:0]           k_q;
  logic signed [COORD_W-1:0] lv_i;
  logic signed [COORD_W-1:0] lv_q;

  assign k_i = word[BITS_PER_SYM-1:HALF];
  assign k_q = word[HALF-1:0];

  always_comb begin
    lv_i = COORD_W'(axis_level(int'(k_i), HALF, COORD_W));
    lv_q = COORD_W'(axis_level(int'(k_q), HALF, COORD_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_i <= '0;
      cur_q <= '0;
    end else if (take) begin
      cur_i <= lv_i;
      cur_q <= lv_q;
    end else if (skip) begin
      cur_i <= '0;
      cur_q <= '0;
    end
  end
endmodule

// File: rtl/qam_tx_mix.sv
module qam_tx_mix
  import qam_tx_pkg::*;
#(
  parameter int SPS       = 40,
  parameter int SPC       = 10,
  parameter int IDX_W     = $clog2(SPS),
  parameter int COORD_W   = 10,
  parameter int TAB_W     = 10,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_mul,
  input  logic                      en_sum,
  input  logic [IDX_W-1:0]          idx,
  input  logic signed [COORD_W-1:0] cur_i,
  input  logic signed [COORD_W-1:0] cur_q,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   out_sample
);
  localparam int PROD_W = COORD_W + TAB_W;
  localparam int SUM_W  = PROD_W + 1;

  logic signed [TAB_W-1:0]  cos_tab [SPS];
  logic signed [TAB_W-1:0]  sin_tab [SPS];
  logic signed [PROD_W-1:0] prod_i;
  logic signed [PROD_W-1:0] prod_q;
  logic signed [SUM_W-1:0]  sum_full;
  logic signed [SUM_W-1:0]  sum_sh;

  for (genvar g = 0; g < SPS; g++) begin : g_tab
    assign cos_tab[g] = TAB_W'(shape_coef(g, SPS, SPC, TAB_W, 1'b0));
    assign sin_tab[g] = TAB_W'(shape_coef(g, SPS, SPC, TAB_W, 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_i <= '0;
      prod_q <= '0;
    end else if (en_mul) begin
      prod_i <= PROD_W'(cur_i) * PROD_W'(cos_tab[idx]);
      prod_q <= PROD_W'(cur_q) * PROD_W'(sin_tab[idx]);
    end
  end

  assign sum_full = SUM_W'(prod_i) + SUM_W'(prod_q);
  assign sum_sh   = sum_full >>> OUT_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= en_sum;
      if (en_sum) out_sample <= OUT_W'(clip(longint'(sum_sh), OUT_W));
    end
  end
endmodule

// File: rtl/qam_tx_mod.sv
module qam_tx_mod #(
  parameter int BITS_PER_SYM = 6,
  parameter int SPS          = 40,
  parameter int SPC          = 10,
  parameter int COORD_W      = 10,
  parameter int TAB_W        = 10,
  parameter int OUT_W        = 16,
  parameter int OUT_SHIFT    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_en,
  input  logic                    in_valid,
  input  logic [BITS_PER_SYM-1:0] in_word,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int IDX_W = $clog2(SPS);

  logic                      take;
  logic                      skip;
  logic [IDX_W-1:0]          samp_idx;
  logic signed [COORD_W-1:0] cur_i;
  logic signed [COORD_W-1:0] cur_q;
  logic                      en_d1;
  logic                      en_d2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d1 <= 1'b0;
      en_d2 <= 1'b0;
    end else begin
      en_d1 <= sample_en;
      en_d2 <= en_d1;
    end
  end

  qam_tx_seq #(.SPS(SPS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .in_valid(in_valid),
    .in_ready(in_ready), .take(take), .skip(skip), .idx(samp_idx)
  );

  qam_tx_map #(.BITS_PER_SYM(BITS_PER_SYM), .COORD_W(COORD_W)) u_map (
    .clk(clk), .rst_n(rst_n), .take(take), .skip(skip), .word(in_word),
    .cur_i(cur_i), .cur_q(cur_q)
  );

  qam_tx_mix #(
    .SPS(SPS), .SPC(SPC), .IDX_W(IDX_W), .COORD_W(COORD_W), .TAB_W(TAB_W),
    .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)
  ) u_mix (
    .clk(clk), .rst_n(rst_n), .en_mul(en_d1), .en_sum(en_d2), .idx(samp_idx),
    .cur_i(cur_i), .cur_q(cur_q), .out_valid(out_valid), .out_sample(out_sample)
  );
endmodule

// File: rtl/qam_tx_chk.sv
module qam_tx_chk #(
  parameter int SPS     = 40,
  parameter int IDX_W   = 6,
  parameter int COORD_W = 10
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sample_en,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      en_d2,
  input logic                      out_valid,
  input logic [IDX_W-1:0]          samp_idx,
  input logic signed [COORD_W-1:0] cur_i,
  input logic signed [COORD_W-1:0] cur_q
);
  p_ready_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> sample_en);

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_d2 |=> out_valid);

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_d2 |=> !out_valid);

  p_origin_on_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (cur_i == '0 && cur_q == '0));

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(samp_idx) && $stable(cur_i) && $stable(cur_q)));

  p_wrap_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && samp_idx == IDX_W'(SPS - 1)) |=> samp_idx == '0);

  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && samp_idx != IDX_W'(SPS - 1)) |=> samp_idx == $past(samp_idx) + IDX_W'(1));
endmodule

bind qam_tx_mod qam_tx_chk #(.SPS(SPS), .IDX_W(IDX_W), .COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .in_valid(in_valid),
  .in_ready(in_ready), .en_d2(en_d2), .out_valid(out_valid),
  .samp_idx(samp_idx), .cur_i(cur_i), .cur_q(cur_q)
);

// File: tb/sim_qam_tx_mod.sv
module sim_qam_tx_mod;
  localparam int BITS = 6;
  localparam int SPS  = 40;
  localparam int SPC  = 10;
  localparam int OW   = 16;
  localparam int SH   = 2;
  localparam int HALF = BITS / 2;

  // word, expected I, expected Q  (R3)
  localparam int NVEC = 8;
  localparam int VEC [NVEC][3] = '{
    '{8'o00, -448, -448}, '{8'o77, 448, 448}, '{8'o70, 448, -448}, '{8'o07, -448, 448},
    '{8'o34, -64, 64},    '{8'o43, 64, -64},  '{8'o12, -320, -192}, '{8'o65, 320, 192}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic in_valid = 1'b0;
  logic [BITS-1:0] in_word = '0;
  logic in_ready;
  logic out_valid;
  logic signed [OW-1:0] out_sample;

  int tests = 0;
  int fails = 0;
  int sat_hi = 0;
  int sat_lo = 0;
  int m_idx = SPS - 1;
  int m_i = 0;
  int m_q = 0;
  int exp_q[$];
  string tag_q[$];
  string cur_tag = "R4";

  always #4 clk = ~clk;

  qam_tx_mod u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .in_valid(in_valid),
    .in_word(in_word), .in_ready(in_ready), .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic int coef(input int i, input bit s);
    real two_pi;
    real win;
    real car;
    real v;
    two_pi = 6.283185307179586;
    win = 0.5 * (1.0 - $cos(two_pi * i / SPS));
    car = s ? $sin(two_pi * i / SPC) : $cos(two_pi * i / SPC);
    v = win * car * 511;
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int lvl(input int k);
    int step;
    step = 512 / (1 << HALF);
    return -((1 << HALF) - 1) * step + 2 * step * k;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input bit en, input bit vld, input logic [BITS-1:0] w,
                      input int ei, input int eq);
    int e;
    @(negedge clk);
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected sample", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check(tag_q.pop_front(), int'(out_sample), e);
      end
    end
    sample_en = en;
    in_valid  = vld;
    in_word   = w;
    #1;
    if (en) check("R2 R9 ready", int'(in_ready), int'(m_idx == SPS - 1));
    else    check("R2 ready without enable", int'(in_ready), 0);
    if (en) begin
      if (m_idx == SPS - 1) begin
        m_idx = 0;
        m_i = vld ? ei : 0;
        m_q = vld ? eq : 0;
      end else begin
        m_idx++;
      end
      e = (m_i * coef(m_idx, 1'b0) + m_q * coef(m_idx, 1'b1)) >>> SH;
      if (e > 32767) e = 32767;
      if (e < -32768) e = -32768;
      if (e == 32767) sat_hi++;
      if (e == -32768) sat_lo++;
      exp_q.push_back(e);
      tag_q.push_back(cur_tag);
    end
  endtask

  task automatic step_word(input bit en, input bit vld, input logic [BITS-1:0] w);
    step(en, vld, w, lvl(int'(w[BITS-1:HALF])), lvl(int'(w[HALF-1:0])));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_sample", int'(out_sample), 0);
    check("R1 in_ready", int'(in_ready), 0);

    // R3 R4 R9: table walk, back to back, enable tied high
    cur_tag = "R3 R4 table";
    for (int v = 0; v < NVEC; v++)
      for (int s = 0; s < SPS; s++)
        step(1'b1, 1'b1, BITS'(VEC[v][0]), VEC[v][1], VEC[v][2]);

    // R6: no word at the boundary -> origin symbol, then late word waits
    cur_tag = "R6 origin";
    for (int s = 0; s < SPS; s++) step_word(1'b1, 1'b0, 6'o55);
    cur_tag = "R6 late word";
    for (int s = 0; s < SPS; s++) step_word(1'b1, s > 10, 6'o71);

    // R8: throttled enable, word changes off-boundary (R2 ignore)
    cur_tag = "R8 throttle";
    for (int s = 0; s < 3 * SPS * 3; s++)
      step_word(s % 3 == 0, 1'b1, BITS'(s / (3 * SPS) * 9 + (s % 5)));

    // R7: corner points again for saturation
    cur_tag = "R7 saturate";
    for (int s = 0; s < SPS; s++) step_word(1'b1, 1'b1, 6'o77);
    for (int s = 0; s < SPS; s++) step_word(1'b1, 1'b1, 6'o00);

    // drain pipeline, R5 count
    cur_tag = "R5 drain";
    for (int s = 0; s < 4; s++) step_word(1'b0, 1'b0, '0);
    check("R5 samples outstanding", exp_q.size(), 0);
    check("R7 high clamp reached", int'(sat_hi > 0), 1);
    check("R7 low clamp reached", int'(sat_lo > 0), 1);

    // R1: reset in mid-symbol
    cur_tag = "R1 pre-reset";
    for (int s = 0; s < 17; s++) step_word(1'b1, 1'b1, 6'o26);
    @(negedge clk);
    sample_en = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_sample after reset", int'(out_sample), 0);
    exp_q.delete();
    tag_q.delete();
    m_idx = SPS - 1;
    m_i = 0;
    m_q = 0;
    cur_tag = "R1 restart";
    for (int s = 0; s < SPS + 4; s++) step_word(s < SPS, 1'b1, 6'o52);
    check("R1 R5 samples outstanding", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule